// File: doc/BRIEF.md
# Sixteen-Function Byte ALU with Registered Result and Flags

This block is the arithmetic and logic stage of a small byte-wide datapath. It combines two operands, `a_i` (normally held in an accumulator) and `b_i` (normally held in a scratch operand register), under a 4-bit operation code. Sixteen operations are available. They cover add, subtract, multiply, increment and decrement, single-bit shifts, the seven basic logic gates, and two constant codes that force all zeros or all ones.

The combinational result is captured into an internal result register only on a clock edge where `load_i` is high. The same edge also updates four status flags: carry, overflow, sign and zero. While `load_i` is low, the result and the flags hold their values. Operand width is a parameter with a default of 8 bits. Every number below assumes that 8-bit default.

Top module: `opsel_alu`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `result_o` is 0x00 and all four flags are 0 until the first load.
- R2: The result and the flags change only on a rising clock edge with `load_i` high. With `load_i` low, they hold their values whatever `a_i`, `b_i` and `op_i` do.
- R3: Code 4'b0001 loads the low byte of A+B. Carry is the unsigned carry out. Overflow is set when both operands have the same sign bit and the sum's sign bit differs from it.
- R4: Code 4'b0010 loads A−B. Carry is a borrow, set when A < B as unsigned values. Overflow is set when the operands' sign bits differ and the result's sign bit differs from A's.
- R5: Code 4'b0011 loads the low byte of the 16-bit unsigned product A*B. Carry is set when the high byte of the product is nonzero. Overflow is 0.
- R6: Code 4'b0100 loads A+1. Its carry is set when A=0xFF, and its overflow is set when A=0x7F. Code 4'b0101 loads A−1. Its carry (borrow) is set when A=0x00, and its overflow is set when A=0x80. B is ignored by both codes.
- R7: Code 4'b0110 shifts A left by one bit, and code 4'b0111 shifts A right by one bit. The vacated bit is filled with 0. Carry takes the bit shifted out: A[7] for a left shift, A[0] for a right shift. Overflow is 0.
- R8: The logic codes are 4'b1000 OR, 4'b1001 AND, 4'b1010 NOT A, 4'b1011 XOR, 4'b1100 NOR, 4'b1101 NAND and 4'b1110 XNOR, all bitwise. Each of them clears carry and overflow.
- R9: Code 4'b0000 loads 0x00 and code 4'b1111 loads 0xFF. Both clear carry and overflow.
- R10: On every load, sign becomes bit 7 of the new result, and zero is set exactly when the new result is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | W (8) | First operand A |
| b_i | input | W (8) | Second operand B |
| op_i | input | 4 | Operation code |
| load_i | input | 1 | Capture strobe for the result register and the flags |
| result_o | output | W (8) | Registered result |
| carry_o | output | 1 | Carry / borrow / shifted-out bit flag |
| ovf_o | output | 1 | Signed overflow flag |
| sign_o | output | 1 | Sign flag (result MSB) |
| zero_o | output | 1 | Zero flag |

## Verification
All state sits in the result and flag registers. A wrong operand mux, a wrong carry-in or a wrong borrow polarity therefore shows up on `result_o` or on a flag one clock edge after the load that used it, and it stays there until the next load. Stale or spurious updates show up as changed outputs during cycles with `load_i` low. Sign and zero can be checked against `result_o` itself on every cycle that follows a load. Directed operands aim at the carry and overflow boundaries (0x7F, 0x80, 0xFF, 0x00) so that a wrong flag appears at the first edge after such a load.

// File: rtl/opsel_alu_pkg.sv
`timescale 1ns/1ps
package opsel_alu_pkg;
  typedef enum logic [3:0] {
    OP_CLR  = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_MUL  = 4'h3,
    OP_INC  = 4'h4,
    OP_DEC  = 4'h5,
    OP_SHL  = 4'h6,
    OP_SHR  = 4'h7,
    OP_OR   = 4'h8,
    OP_AND  = 4'h9,
    OP_NOT  = 4'hA,
    OP_XOR  = 4'hB,
    OP_NOR  = 4'hC,
    OP_NAND = 4'hD,
    OP_XNOR = 4'hE,
    OP_SET  = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic carry;
    logic ovf;
  } cv_t;

  typedef enum logic [1:0] {
    CLS_ADDER = 2'd0,
    CLS_MUL   = 2'd1,
    CLS_BITS  = 2'd2
  } op_class_e;

  function automatic op_class_e op_class(alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: return CLS_ADDER;
      OP_MUL:                         return CLS_MUL;
      default:                        return CLS_BITS;
    endcase
  endfunction
endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output cv_t          cv_o
);
  logic [W-1:0] y_op;
  logic         cin;
  logic [W:0]   sum;
  logic         borrow_mode;

  // one adder serves add, sub, inc and dec through operand/carry-in selection
  always_comb begin
    case (op_i)
      OP_SUB:  begin y_op = ~b_i;     cin = 1'b1; end
      OP_INC:  begin y_op = '0;       cin = 1'b1; end
      OP_DEC:  begin y_op = '1;       cin = 1'b0; end
      default: begin y_op = b_i;      cin = 1'b0; end
    endcase
  end

  assign sum         = {1'b0, a_i} + {1'b0, y_op} + {{W{1'b0}}, cin};
  assign borrow_mode = (op_i == OP_SUB) || (op_i == OP_DEC);
  assign res_o       = sum[W-1:0];
  assign cv_o.carry  = borrow_mode ? ~sum[W] : sum[W];
  assign cv_o.ovf    = (a_i[W-1] == y_op[W-1]) && (sum[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_mul.sv
`timescale 1ns/1ps
module alu_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         hi_nz_o
);
  localparam int PW = 2 * W;
  logic [PW-1:0] prod;

  assign prod    = PW'(a_i) * PW'(b_i);
  assign res_o   = prod[W-1:0];
  assign hi_nz_o = |prod[PW-1:W];
endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  logic [W:0] a_ext;
  assign a_ext = {1'b0, a_i};

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic lo_nb, hi_nb;
    // neighbour bits for shifting, zero fill at the ends
    assign lo_nb = (i == 0) ? 1'b0 : a_ext[(i == 0) ? 0 : i-1];
    assign hi_nb = a_ext[i+1];
    always_comb begin
      case (op_i)
        OP_SHL:  res_o[i] = lo_nb;
        OP_SHR:  res_o[i] = hi_nb;
        OP_OR:   res_o[i] = a_i[i] | b_i[i];
        OP_AND:  res_o[i] = a_i[i] & b_i[i];
        OP_NOT:  res_o[i] = ~a_i[i];
        OP_XOR:  res_o[i] = a_i[i] ^ b_i[i];
        OP_NOR:  res_o[i] = ~(a_i[i] | b_i[i]);
        OP_NAND: res_o[i] = ~(a_i[i] & b_i[i]);
        OP_XNOR: res_o[i] = ~(a_i[i] ^ b_i[i]);
        OP_SET:  res_o[i] = 1'b1;
        default: res_o[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (op_i)
      OP_SHL:  carry_o = a_i[W-1];
      OP_SHR:  carry_o = a_i[0];
      default: carry_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/opsel_alu.sv
`timescale 1ns/1ps
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic         load_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         sign_o,
  output logic         zero_o
);
  alu_op_e      op;
  logic [W-1:0] as_res, mul_res, bit_res, nxt_res;
  cv_t          as_cv, nxt_cv;
  logic         mul_hi_nz, bit_carry;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(as_res), .cv_o(as_cv)
  );

  alu_mul #(.W(W)) u_mul (
    .a_i(a_i), .b_i(b_i), .res_o(mul_res), .hi_nz_o(mul_hi_nz)
  );

  alu_bitwise #(.W(W)) u_bits (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(bit_res), .carry_o(bit_carry)
  );

  always_comb begin
    case (op_class(op))
      CLS_ADDER: begin nxt_res = as_res;  nxt_cv = as_cv; end
      CLS_MUL:   begin nxt_res = mul_res; nxt_cv = '{carry: mul_hi_nz, ovf: 1'b0}; end
      default:   begin nxt_res = bit_res; nxt_cv = '{carry: bit_carry, ovf: 1'b0}; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
      sign_o   <= 1'b0;
      zero_o   <= 1'b0;
    end else if (load_i) begin
      result_o <= nxt_res;
      carry_o  <= nxt_cv.carry;
      ovf_o    <= nxt_cv.ovf;
      sign_o   <= nxt_res[W-1];
      zero_o   <= (nxt_res == '0);
    end
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(result_o) && $stable(carry_o) && $stable(ovf_o)
                && $stable(sign_o) && $stable(zero_o));

  assert_zero_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> zero_o == (result_o == '0));

  assert_sign_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sign_o == result_o[W-1]);

  assert_logic_clears_cv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && op_i[3] && op_i != 4'hF |=> !carry_o && !ovf_o);

  assert_const_codes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (op_i == 4'h0 || op_i == 4'hF)
      |=> (result_o == (op_i == 4'h0 ? '0 : '1) || result_o == $past(op_i == 4'h0 ? {W{1'b0}} : {W{1'b1}}))
          && !carry_o && !ovf_o);

  assert_mul_no_ovf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && op_i == 4'h3 |=> !ovf_o);
endmodule

// File: tb/opsel_alu_test.sv
`timescale 1ns/1ps
module opsel_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [3:0] op = '0;
  logic       load = 1'b0;
  logic [7:0] res;
  logic       c, v, s, z;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  opsel_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .op_i(op), .load_i(load),
    .result_o(res), .carry_o(c), .ovf_o(v), .sign_o(s), .zero_o(z)
  );

  // expected {carry, ovf, sign, zero, result}
  function automatic logic [11:0] model(logic [7:0] x, logic [7:0] y, logic [3:0] o);
    int ux, uy, sx, sy, t, st;
    logic [7:0] r;
    logic cf, vf;
    ux = int'(x); uy = int'(y);
    sx = int'($signed(x)); sy = int'($signed(y));
    cf = 0; vf = 0; r = 0;
    case (o)
      4'h0: r = 8'h00;
      4'h1: begin t = ux + uy; r = t[7:0]; cf = t > 255; st = sx + sy; vf = st > 127 || st < -128; end
      4'h2: begin t = ux - uy; r = t[7:0]; cf = ux < uy; st = sx - sy; vf = st > 127 || st < -128; end
      4'h3: begin t = ux * uy; r = t[7:0]; cf = t > 255; end
      4'h4: begin t = ux + 1; r = t[7:0]; cf = ux == 255; st = sx + 1; vf = st > 127; end
      4'h5: begin t = ux - 1; r = t[7:0]; cf = ux == 0; st = sx - 1; vf = st < -128; end
      4'h6: begin t = ux * 2; r = t[7:0]; cf = x[7]; end
      4'h7: begin t = ux / 2; r = t[7:0]; cf = x[0]; end
      4'h8: r = x | y;
      4'h9: r = x & y;
      4'hA: r = ~x;
      4'hB: r = x ^ y;
      4'hC: r = ~(x | y);
      4'hD: r = ~(x & y);
      4'hE: r = ~(x ^ y);
      default: r = 8'hFF;
    endcase
    return {cf, vf, r[7], r == 8'h00, r};
  endfunction

  task automatic check(string req, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got c=%b v=%b s=%b z=%b r=%h, expected c=%b v=%b s=%b z=%b r=%h",
               req, got[11], got[10], got[9], got[8], got[7:0],
               exp[11], exp[10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic run_op(string req, logic [7:0] x, logic [7:0] y, logic [3:0] o);
    @(negedge clk);
    a = x; b = y; op = o; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check(req, {c, v, s, z, res}, model(x, y, o));
  endtask

  task automatic t_reset;
    check("R1 reset", {c, v, s, z, res}, 12'h000);
  endtask

  task automatic t_hold;
    logic [11:0] snap;
    run_op("R2 load", 8'h12, 8'h34, 4'h1);
    snap = {c, v, s, z, res};
    @(negedge clk);
    a = 8'hFF; b = 8'hFF; op = 4'hF; load = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 hold without load", {c, v, s, z, res}, snap);
    op = 4'h0;
    @(negedge clk);
    check("R2 hold op change", {c, v, s, z, res}, snap);
  endtask

  task automatic t_add;
    run_op("R3 add plain", 8'h12, 8'h34, 4'h1);
    run_op("R3 add carry", 8'hFF, 8'h02, 4'h1);
    run_op("R3 add ovf pos", 8'h7F, 8'h01, 4'h1);
    run_op("R3 add ovf neg", 8'h80, 8'h80, 4'h1);
    run_op("R10 add zero", 8'h80, 8'h80, 4'h1);
  endtask

  task automatic t_sub;
    run_op("R4 sub plain", 8'h50, 8'h20, 4'h2);
    run_op("R4 sub borrow", 8'h10, 8'h20, 4'h2);
    run_op("R4 sub ovf", 8'h80, 8'h01, 4'h2);
    run_op("R4 sub ovf2", 8'h7F, 8'hFF, 4'h2);
    run_op("R4 sub equal zero", 8'h33, 8'h33, 4'h2);
  endtask

  task automatic t_mul;
    run_op("R5 mul small", 8'h0C, 8'h0A, 4'h3);
    run_op("R5 mul high", 8'h10, 8'h10, 4'h3);
    run_op("R5 mul big", 8'hFF, 8'hFF, 4'h3);
  endtask

  task automatic t_incdec;
    run_op("R6 inc", 8'h41, 8'hAA, 4'h4);
    run_op("R6 inc wrap", 8'hFF, 8'h00, 4'h4);
    run_op("R6 inc ovf", 8'h7F, 8'h55, 4'h4);
    run_op("R6 dec", 8'h41, 8'hAA, 4'h5);
    run_op("R6 dec borrow", 8'h00, 8'h11, 4'h5);
    run_op("R6 dec ovf", 8'h80, 8'hFF, 4'h5);
  endtask

  task automatic t_shift;
    run_op("R7 shl", 8'h81, 8'hFF, 4'h6);
    run_op("R7 shl nocarry", 8'h40, 8'h00, 4'h6);
    run_op("R7 shr", 8'h81, 8'hFF, 4'h7);
    run_op("R7 shr nocarry", 8'hFE, 8'h01, 4'h7);
  endtask

  task automatic t_logic;
    // set carry first, then confirm logic op clears it
    run_op("R8 prep carry", 8'hFF, 8'h01, 4'h1);
    for (int k = 8; k <= 14; k++) begin
      run_op("R8 logic A5/3C", 8'hA5, 8'h3C, 4'(k));
      run_op("R8 logic F0/0F", 8'hF0, 8'h0F, 4'(k));
    end
  endtask

  task automatic t_const;
    run_op("R9 preset", 8'h12, 8'h34, 4'hF);
    run_op("R9 clear", 8'hFF, 8'hFF, 4'h0);
    run_op("R6 set ovf", 8'h7F, 8'h00, 4'h4);
    run_op("R9 preset clears flags", 8'h00, 8'h00, 4'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_add();
    t_sub();
    t_mul();
    t_incdec();
    t_shift();
    t_logic();
    t_const();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule